// File: doc/BRIEF.md
# Receive FIFO with Trigger Interrupt and Line Status

This block is the receive-side queue of a 16550-class serial port. A receive shifter pushes each finished character together with its parity, framing and break flags. The CPU side pops characters from the head of the queue. While it holds data, the block reports how full it is and what is wrong with the head character. It raises a receive-data interrupt that follows the fill level against a selectable threshold. It also assembles the 8-bit line status word, taking the two transmit-empty bits from the transmitter.

Writes form a stream with no back-pressure: the shifter cannot stall, so `wr_valid` is a one-cycle strobe and there is no ready signal. A character that arrives while the queue is full, with no pop in the same cycle, is dropped and flags an overrun. Reads are a show-ahead valid/ready stream. `rd_valid` is high whenever the queue holds data, and `rd_data` always shows the head. A pop happens on a clock edge where `rd_valid` and `rd_ready` are both high. A ready with nothing valid has no effect. A full queue that is popped in the same cycle still accepts a new write.

Top module: `rx_fifo_stat`

## Requirements
- R1: After reset, `rd_valid`, `rx_irq`, `lsr[0]`, `lsr[1]`, `lsr[4:2]` and `lsr[7]` are 0, and `isr_code` is 4'b0001.
- R2: Characters leave in the order they were accepted. `rd_valid` is high exactly when the queue is not empty. `rd_data` shows the head character, or 0 when the queue is empty.
- R3: With `fifo_en`=1 the queue holds 16 characters. A write to a full queue with no pop in the same cycle is discarded and sets `lsr[1]` (overrun). The overrun bit is cleared by an `lsr_rd` strobe in a cycle with no new overrun.
- R4: `trig_sel` picks the threshold: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 characters. When `rda_ie`=1, `rx_irq` is high exactly while the fill level is at or above the threshold, so it drops as soon as pops take the fill below it.
- R5: `isr_code` is 4'b0100 while `rx_irq` is high, and 4'b0001 otherwise.
- R6: `lsr[0]` (data ready) is high whenever at least one character is held.
- R7: `lsr[2]`, `lsr[3]` and `lsr[4]` are the parity, framing and break flags of the head character. These flags enter as `wr_err[0]`, `wr_err[1]` and `wr_err[2]`. The three bits are 0 when the queue is empty.
- R8: `lsr[5]` equals `tx_fifo_empty`, and `lsr[6]` is the AND of `tx_fifo_empty` and `tx_shift_empty`.
- R9: `lsr[7]` sets after any accepted character carries an error flag. An `lsr_rd` clears it only in a cycle where no errored character is held and none is being accepted.
- R10: With `rda_ie`=0 (polled mode), `rx_irq` stays 0 and `isr_code` stays 4'b0001, while all line status bits keep updating.
- R11: A `fifo_clr` strobe empties the queue, clears `lsr[0]`, `lsr[1]` and `lsr[7]`, and resets the error count by the next cycle. It takes priority over a write or pop in the same cycle.
- R12: With `fifo_en`=0 the queue holds one character and the threshold is 1 regardless of `trig_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Character strobe from the receive shifter |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error flags: [0] parity, [1] framing, [2] break |
| rd_ready | input | 1 | CPU read strobe (pop) |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 8 | Head character |
| fifo_en | input | 1 | 1: 16-deep queue, 0: single holding register |
| fifo_clr | input | 1 | Synchronous queue clear |
| trig_sel | input | 2 | Interrupt threshold select |
| rda_ie | input | 1 | Receive-data interrupt enable |
| lsr_rd | input | 1 | Line status read strobe |
| tx_fifo_empty | input | 1 | Transmit queue empty, from the transmitter |
| tx_shift_empty | input | 1 | Transmit shift register empty, from the transmitter |
| rx_irq | output | 1 | Receive-data interrupt |
| isr_code | output | 4 | Pending interrupt source code |
| lsr | output | 8 | Line status word |

## Verification
Every registered effect of a write, pop, clear or status read shows on the outputs one clock edge later. Every output is combinational from registers, and the transmit-empty and configuration inputs reach their outputs with no register in between. The bench drives each stimulus on a falling edge and lets one rising edge pass. It then compares all outputs at the next falling edge against a queue model built from the requirements. This comparison is repeated after every single operation of the fill, drain, overrun and clear sweeps, across all four thresholds and both queue modes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CHAR_W = 8;
  localparam int FLAG_W = 3;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] data;
  } rxf_entry_t;

  localparam logic [3:0] SRC_NONE = 4'b0001;
  localparam logic [3:0] SRC_RDA  = 4'b0100;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fifo_en,
  input  logic          push_req,
  input  rxf_entry_t    wr_entry,
  input  logic          pop_req,
  output rxf_entry_t    head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          accept,
  output logic          pop
);
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  rxf_entry_t    mem [DEPTH];

  assign full   = fifo_en ? (cnt == CW'(DEPTH)) : (cnt != '0);
  assign pop    = pop_req && (cnt != '0);
  assign accept = push_req && (!full || pop);
  assign count  = cnt;
  assign head   = (cnt == '0) ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (accept && !clr) mem[wptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (accept) wptr <= wptr + 1'b1;
      if (pop)    rptr <= rptr + 1'b1;
      case ({accept, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_clr_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  p_pop_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !accept && !clr) |=> (cnt == $past(cnt) - 1'b1));
  p_single_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && cnt != '0 && push_req && !pop_req && !clr) |=> $stable(cnt));
endmodule

// File: rtl/rxf_errtrack.sv
module rxf_errtrack
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              accept,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic              pop,
  input  logic [FLAG_W-1:0] head_flags,
  input  logic              lsr_rd,
  output logic              fifo_err
);
  logic [CW-1:0] errcnt;
  logic inc, dec;

  assign inc = accept && (|in_flags);
  assign dec = pop && (|head_flags);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      errcnt   <= '0;
      fifo_err <= 1'b0;
    end else begin
      case ({inc, dec})
        2'b10:   errcnt <= errcnt + 1'b1;
        2'b01:   errcnt <= errcnt - 1'b1;
        default: errcnt <= errcnt;
      endcase
      if (inc)                          fifo_err <= 1'b1;
      else if (lsr_rd && errcnt == '0)  fifo_err <= 1'b0;
    end
  end

  p_err_summary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (errcnt != '0) |-> fifo_err);
  p_err_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    errcnt <= CW'(DEPTH));
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] count,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic          rda_ie,
  input  logic          ovr_evt,
  input  logic          lsr_rd,
  input  rxf_entry_t    head,
  input  logic          fifo_err,
  input  logic          tx_fifo_empty,
  input  logic          tx_shift_empty,
  output logic          rx_irq,
  output logic [3:0]    isr_code,
  output logic [7:0]    lsr
);
  localparam logic [CW-1:0] LVL0 = CW'(1);
  localparam logic [CW-1:0] LVL1 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LVL2 = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LVL3 = CW'(DEPTH - 2);

  logic [CW-1:0] thresh;
  logic          ovr;
  logic          level_hit;

  always_comb begin
    if (!fifo_en) thresh = LVL0;
    else begin
      case (trig_sel)
        2'd0:    thresh = LVL0;
        2'd1:    thresh = LVL1;
        2'd2:    thresh = LVL2;
        default: thresh = LVL3;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) ovr <= 1'b0;
    else if (ovr_evt)  ovr <= 1'b1;
    else if (lsr_rd)   ovr <= 1'b0;
  end

  assign level_hit = (count >= thresh);
  assign rx_irq    = rda_ie && level_hit;
  assign isr_code  = rx_irq ? SRC_RDA : SRC_NONE;

  assign lsr = {fifo_err,
                tx_fifo_empty & tx_shift_empty,
                tx_fifo_empty,
                head.brk, head.frm, head.par,
                ovr,
                count != '0};

  p_ovr_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !clr) |=> lsr[1]);
  p_irq_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (count != '0));
  p_clr_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!lsr[1] && !lsr[7]));
endmodule

// File: rtl/rx_fifo_stat.sv
module rx_fifo_stat
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  input  logic [2:0]  wr_err,
  input  logic        rd_ready,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  input  logic        fifo_en,
  input  logic        fifo_clr,
  input  logic [1:0]  trig_sel,
  input  logic        rda_ie,
  input  logic        lsr_rd,
  input  logic        tx_fifo_empty,
  input  logic        tx_shift_empty,
  output logic        rx_irq,
  output logic [3:0]  isr_code,
  output logic [7:0]  lsr
);
  localparam int CW = $clog2(DEPTH + 1);

  rxf_entry_t    wr_entry, head;
  logic [CW-1:0] count;
  logic          full, accept, pop, fifo_err, ovr_evt;

  assign wr_entry = '{brk: wr_err[2], frm: wr_err[1], par: wr_err[0], data: wr_data};
  assign ovr_evt  = wr_valid && full && !pop;
  assign rd_valid = (count != '0);
  assign rd_data  = head.data;

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .fifo_en(fifo_en),
    .push_req(wr_valid), .wr_entry(wr_entry), .pop_req(rd_ready),
    .head(head), .count(count), .full(full), .accept(accept), .pop(pop)
  );

  rxf_errtrack #(.DEPTH(DEPTH)) u_err (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .accept(accept),
    .in_flags(wr_err), .pop(pop),
    .head_flags({head.brk, head.frm, head.par}),
    .lsr_rd(lsr_rd), .fifo_err(fifo_err)
  );

  rxf_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .count(count),
    .fifo_en(fifo_en), .trig_sel(trig_sel), .rda_ie(rda_ie),
    .ovr_evt(ovr_evt), .lsr_rd(lsr_rd), .head(head), .fifo_err(fifo_err),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
    .rx_irq(rx_irq), .isr_code(isr_code), .lsr(lsr)
  );

  p_valid_tracks_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !fifo_clr) |=> rd_valid);
endmodule

// File: tb/rx_fifo_stat_tb.sv
`timescale 1ns/1ps
module rx_fifo_stat_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, rd_ready = 0, fifo_en = 1, fifo_clr = 0, rda_ie = 1, lsr_rd = 0;
  logic tx_fifo_empty = 0, tx_shift_empty = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_err = 0;
  logic [1:0] trig_sel = 0;
  logic rd_valid, rx_irq;
  logic [7:0] rd_data, lsr;
  logic [3:0] isr_code;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [10:0] q[$];
  bit m_ovr = 0, m_ferr = 0;

  always #2 clk = ~clk;

  rx_fifo_stat u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_err(wr_err),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .fifo_en(fifo_en),
    .fifo_clr(fifo_clr), .trig_sel(trig_sel), .rda_ie(rda_ie), .lsr_rd(lsr_rd),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
    .rx_irq(rx_irq), .isr_code(isr_code), .lsr(lsr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int thresh();
    if (!fifo_en) return 1;
    case (trig_sel)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic verify();
    logic [10:0] h;
    bit irq_e;
    h = (q.size() != 0) ? q[0] : 11'd0;
    irq_e = rda_ie && (q.size() >= thresh());
    chk("R2 rd_valid", rd_valid, q.size() != 0);
    chk("R2 rd_data", rd_data, h[7:0]);
    chk("R6 data ready", lsr[0], q.size() != 0);
    chk("R3 overrun", lsr[1], m_ovr);
    chk("R7 head flags", lsr[4:2], h[10:8]);
    chk("R8 tx empty", lsr[5], tx_fifo_empty);
    chk("R8 tx idle", lsr[6], tx_fifo_empty & tx_shift_empty);
    chk("R9 fifo error", lsr[7], m_ferr);
    chk(rda_ie ? "R4 irq" : "R10 polled irq", rx_irq, irq_e);
    chk("R5 isr", isr_code, irq_e ? 4'b0100 : 4'b0001);
  endtask

  task automatic step(input bit wv, input logic [7:0] wd, input logic [2:0] we,
                      input bit rr, input bit lr, input bit clr);
    int cap, ecnt;
    bit pop, full, acc;
    @(negedge clk);
    wr_valid = wv; wr_data = wd; wr_err = we; rd_ready = rr; lsr_rd = lr; fifo_clr = clr;
    cap = fifo_en ? 16 : 1;
    ecnt = 0;
    foreach (q[i]) if (q[i][10:8] != 0) ecnt++;
    if (clr) begin
      q.delete(); m_ovr = 0; m_ferr = 0;
    end else begin
      pop = rr && q.size() != 0;
      full = q.size() >= cap;
      acc = wv && (!full || pop);
      if (pop) void'(q.pop_front());
      if (acc) q.push_back({we, wd});
      if (wv && !acc) m_ovr = 1; else if (lr) m_ovr = 0;
      if (acc && we != 0) m_ferr = 1; else if (lr && ecnt == 0) m_ferr = 0;
    end
    @(negedge clk);
    wr_valid = 0; rd_ready = 0; lsr_rd = 0; fifo_clr = 0;
    verify();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 irq", rx_irq, 0);
    chk("R1 isr", isr_code, 4'b0001);
    chk("R1 lsr", {lsr[7], lsr[4:0]}, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 R4 R5 R2: fill, overflow and drain at every threshold
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      step(0, 0, 0, 0, 1, 1);
      for (int k = 0; k < 16; k++) step(1, 8'(k * 7 + s), 0, 0, 0, 0);
      step(1, 8'hEE, 0, 0, 0, 0);
      step(1, 8'hEF, 0, 1, 0, 0);
      for (int k = 0; k < 17; k++) step(0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 1, 0);
    end

    // R10: polled mode
    rda_ie = 0;
    trig_sel = 2'd1;
    for (int k = 0; k < 16; k++) step(1, 8'(200 + k), 0, 0, 0, 0);
    for (int k = 0; k < 16; k++) step(0, 0, 0, 1, 0, 0);
    rda_ie = 1;

    // R7 R9: error flags follow the head; summary sticks until read with none held
    for (int e = 0; e < 8; e++) step(1, 8'(e + 16), 3'(e), 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    step(1, 8'h55, 3'b100, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0);

    // R8: transmit status combinations
    for (int t = 0; t < 4; t++) begin
      tx_fifo_empty = t[0]; tx_shift_empty = t[1];
      step(0, 0, 0, 0, 0, 0);
    end

    // R11: clear mid-fill with a coincident write and error
    for (int k = 0; k < 5; k++) step(1, 8'(k), 3'b010, 0, 0, 0);
    step(1, 8'h77, 3'b001, 1, 0, 1);
    step(1, 8'h78, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);

    // R12: single holding register mode
    fifo_en = 0;
    trig_sel = 2'd3;
    step(0, 0, 0, 0, 0, 1);
    step(1, 8'hA1, 0, 0, 0, 0);
    step(1, 8'hA2, 0, 0, 0, 0);
    step(1, 8'hA3, 0, 1, 0, 0);
    step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 0);
    fifo_en = 1;
    step(0, 0, 0, 0, 1, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule